// File: doc/BRIEF.md
# Counting-Semaphore Descriptor Dispatcher

This block runs work on behalf of several independent channels that share one memory read port and one processing engine. Software points a channel at a seven-word work descriptor in memory and then adds to that channel's counting semaphore. While the semaphore is nonzero and the channel is enabled, the channel competes for the shared resources. When it wins, the dispatcher reads the descriptor word by word, presents its fields to the engine with a one-cycle start strobe, waits for the engine's done strobe, and then retires the job.

On retirement, a descriptor can take one count off its semaphore, raise the channel's interrupt bit, and move the channel on to a linked descriptor. A nonzero error code returned by the engine is held in the channel's status, drains the semaphore and always raises the interrupt. Software reads and clears all of this state through a simple register port. Status registers are cleared by writing ones.

Top module: `desc_dispatch`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and neither `mem_req` nor `eng_start` is asserted.
- R2: A write to a channel's semaphore register (channel base + 0x10) adds the low byte of the written data to the semaphore. Writing 1 therefore adds one count. The sum saturates at 255, and the register reads back the count in bits [7:0].
- R3: A granted channel reads its descriptor as seven single-beat reads at byte addresses pointer, pointer+4, and so on up to pointer+24, one after another. The order of the words is link, control 0, control 1, source, destination, length, key address. `mem_req` and `mem_addr` stay steady until `mem_vld` is seen.
- R4: After the seventh word, `eng_start` is high for exactly one cycle. `eng_ctrl1`, `eng_src`, `eng_dst`, `eng_len` and `eng_key` carry the descriptor words. `eng_ctrl0` carries control 0 masked to its operation flags (bits 5, 6, 8, 9, 11, 12 and 13, mask 0x3B60).
- R5: If bit 1 of control 0 is set, a successful retirement removes one count from the semaphore; if it is clear, the count is left alone. A software increment that lands in the same cycle is applied as well. For example, 255 plus 1 minus 1 gives 255.
- R6: If bit 0 of control 0 is set, a successful retirement sets bit n of the global status register (0x10) for channel n. `irq` is the OR of those bits. Writing a mask to 0x18 clears the matching bits.
- R7: After a successful retirement, if the semaphore is still nonzero and the link word is nonzero, the link is loaded into the channel pointer (channel base + 0x00) and the linked descriptor runs next. Otherwise the pointer keeps the address of the descriptor that just finished. A channel whose semaphore is still nonzero re-runs the descriptor at its pointer.
- R8: A channel whose bit in the enable register (0x20) is clear never starts, whatever its semaphore holds.
- R9: Only one channel holds the shared port and engine at a time. When several channels are ready, the lowest-numbered one is granted.
- R10: A nonzero `eng_err` at done is stored in the channel status (channel base + 0x20, bits [7:0]). The semaphore is cleared, the pointer is not advanced, and the channel's global status bit is set even without the interrupt flag. Writing a mask to channel base + 0x28 clears those status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Descriptor read request, held until `mem_vld` |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_vld | input | 1 | Read data valid, one cycle |
| mem_data | input | 32 | Read data |
| eng_start | output | 1 | One-cycle engine launch |
| eng_ctrl0 | output | 32 | Operation flags from control word 0 |
| eng_ctrl1 | output | 32 | Control word 1 |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_len | output | 32 | Byte length |
| eng_key | output | 32 | Key/payload address |
| eng_done | input | 1 | One-cycle engine completion |
| eng_err | input | 8 | Engine error code, sampled with `eng_done` |
| irq | output | 1 | OR of global status bits |

## Verification
The hardest case to reach from the ports is a software semaphore write that lands in the very cycle a decrementing descriptor retires, with the count already at its ceiling. The bench watches `eng_done` from its engine model and launches the register write so that it meets the retirement edge. After that, the channel must run exactly once more and settle at 254. Enable masks are swept over all sixteen values to cover grant order, and a full increment sweep covers saturation.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int DESC_WORDS = 7;
  localparam int W_LINK = 0;
  localparam int W_CTL0 = 1;
  localparam int W_CTL1 = 2;
  localparam int W_SRC  = 3;
  localparam int W_DST  = 4;
  localparam int W_LEN  = 5;
  localparam int W_KEY  = 6;

  localparam int C0_IRQ = 0;
  localparam int C0_DEC = 1;
  localparam logic [31:0] OP_MASK = 32'h0000_3B60;

  localparam int G_STAT   = 'h10;
  localparam int G_CLR    = 'h18;
  localparam int G_EN     = 'h20;
  localparam int CH_BASE  = 'h100;
  localparam int CH_STRIDE = 'h40;
  localparam logic [5:0] OFF_PTR  = 6'h00;
  localparam logic [5:0] OFF_SEM  = 6'h10;
  localparam logic [5:0] OFF_CST  = 6'h20;
  localparam logic [5:0] OFF_CCLR = 6'h28;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_START, SQ_WAIT, SQ_RET
  } seq_state_t;

  function automatic logic [31:0] word_addr(logic [31:0] base, logic [2:0] idx);
    return base + {27'd0, idx, 2'b00};
  endfunction
endpackage

// File: rtl/dd_sem.sv
module dd_sem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inc,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] val,
  output logic [W-1:0] nxt
);
  localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

  function automatic logic [W-1:0] step(logic [W-1:0] cur, logic [W-1:0] add,
                                        logic take, logic wipe);
    logic [W:0] s;
    s = (wipe ? '0 : {1'b0, cur}) + {1'b0, add};
    if (take && !wipe && s != '0) s = s - 1'b1;
    if (s > TOP) s = TOP;
    return s[W-1:0];
  endfunction

  logic [W-1:0] val_q;
  assign nxt = step(val_q, inc, dec, clr);
  assign val = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= nxt;
  end
endmodule

// File: rtl/dd_arb.sv
module dd_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // isolate the lowest set bit: channel 0 has top priority
  assign gnt = req & (~req + 1'b1);
  assign any = |req;
endmodule

// File: rtl/dd_seq.sv
module dd_seq
  import dd_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int ERRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  gnt,
  input  logic            gnt_any,
  input  logic [31:0]     gnt_ptr,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_vld,
  input  logic [31:0]     mem_data,
  output logic            eng_start,
  output logic [31:0]     eng_ctrl0,
  output logic [31:0]     eng_ctrl1,
  output logic [31:0]     eng_src,
  output logic [31:0]     eng_dst,
  output logic [31:0]     eng_len,
  output logic [31:0]     eng_key,
  input  logic            eng_done,
  input  logic [ERRW-1:0] eng_err,
  output logic [NCH-1:0]  act_oh,
  output logic            grant_fire,
  output logic            ret_fire,
  output logic            ret_dec,
  output logic            ret_irq,
  output logic [ERRW-1:0] ret_err,
  output logic [31:0]     ret_link
);
  localparam logic [2:0] LAST = 3'(DESC_WORDS - 1);

  seq_state_t      st_q;
  logic [2:0]      widx_q;
  logic [31:0]     base_q;
  logic [31:0]     dw_q [DESC_WORDS];
  logic [NCH-1:0]  act_q;
  logic [ERRW-1:0] err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      widx_q <= '0;
      base_q <= '0;
      act_q  <= '0;
      err_q  <= '0;
      for (int i = 0; i < DESC_WORDS; i++) dw_q[i] <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (gnt_any) begin
          act_q  <= gnt;
          base_q <= gnt_ptr;
          widx_q <= '0;
          st_q   <= SQ_FETCH;
        end
        SQ_FETCH: if (mem_vld) begin
          dw_q[widx_q] <= mem_data;
          if (widx_q == LAST) st_q <= SQ_START;
          else                widx_q <= widx_q + 1'b1;
        end
        SQ_START: st_q <= SQ_WAIT;
        SQ_WAIT: if (eng_done) begin
          err_q <= eng_err;
          st_q  <= SQ_RET;
        end
        SQ_RET: begin
          act_q <= '0;
          st_q  <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req    = (st_q == SQ_FETCH);
  assign mem_addr   = word_addr(base_q, widx_q);
  assign eng_start  = (st_q == SQ_START);
  assign eng_ctrl0  = dw_q[W_CTL0] & OP_MASK;
  assign eng_ctrl1  = dw_q[W_CTL1];
  assign eng_src    = dw_q[W_SRC];
  assign eng_dst    = dw_q[W_DST];
  assign eng_len    = dw_q[W_LEN];
  assign eng_key    = dw_q[W_KEY];
  assign act_oh     = act_q;
  assign grant_fire = (st_q == SQ_IDLE) && gnt_any;
  assign ret_fire   = (st_q == SQ_RET);
  assign ret_dec    = dw_q[W_CTL0][C0_DEC];
  assign ret_irq    = dw_q[W_CTL0][C0_IRQ];
  assign ret_err    = err_q;
  assign ret_link   = dw_q[W_LINK];
endmodule

// File: rtl/desc_dispatch.sv
module desc_dispatch
  import dd_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SEMW = 8,
  parameter int AW   = 12,
  parameter int ERRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_vld,
  input  logic [31:0]     mem_data,
  output logic            eng_start,
  output logic [31:0]     eng_ctrl0,
  output logic [31:0]     eng_ctrl1,
  output logic [31:0]     eng_src,
  output logic [31:0]     eng_dst,
  output logic [31:0]     eng_len,
  output logic [31:0]     eng_key,
  input  logic            eng_done,
  input  logic [ERRW-1:0] eng_err,
  output logic            irq
);
  localparam int SELW = AW - 6;

  // register decode
  logic [AW-1:0]   rel;
  logic [SELW-1:0] ch_sel;
  logic [5:0]      ch_off;
  logic            in_ch;
  assign rel    = reg_addr - AW'(CH_BASE);
  assign ch_sel = rel[AW-1:6];
  assign ch_off = reg_addr[5:0];
  assign in_ch  = (reg_addr >= AW'(CH_BASE)) && (rel < AW'(NCH * CH_STRIDE));

  logic wr_gclr, wr_en;
  assign wr_gclr = reg_wr && (reg_addr == AW'(G_CLR));
  assign wr_en   = reg_wr && (reg_addr == AW'(G_EN));

  // channel state
  logic [NCH-1:0]  en_q, gstat_q, ready, gnt, hit, irq_set;
  logic            gnt_any;
  logic [31:0]     cmdptr_q [NCH];
  logic [ERRW-1:0] chst_q   [NCH];
  logic [SEMW-1:0] sem_v    [NCH];
  logic [SEMW-1:0] sem_nx   [NCH];
  logic [31:0]     gnt_ptr;

  // sequencer events
  logic [NCH-1:0]  act_oh;
  logic            grant_fire, ret_fire, ret_dec, ret_irq, ret_bad;
  logic [ERRW-1:0] ret_err;
  logic [31:0]     ret_link;
  assign ret_bad = (ret_err != '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, wr_ptr, wr_sem, wr_cclr;
    assign sel     = reg_wr && in_ch && (ch_sel == SELW'(c));
    assign wr_ptr  = sel && (ch_off == OFF_PTR);
    assign wr_sem  = sel && (ch_off == OFF_SEM);
    assign wr_cclr = sel && (ch_off == OFF_CCLR);
    assign hit[c]     = ret_fire && act_oh[c];
    assign irq_set[c] = hit[c] && (ret_irq || ret_bad);
    assign ready[c]   = en_q[c] && (sem_v[c] != '0);

    dd_sem #(.W(SEMW)) u_sem (
      .clk (clk),
      .rst_n (rst_n),
      .inc (wr_sem ? reg_wdata[SEMW-1:0] : '0),
      .dec (hit[c] && ret_dec),
      .clr (hit[c] && ret_bad),
      .val (sem_v[c]),
      .nxt (sem_nx[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmdptr_q[c] <= '0;
        chst_q[c]   <= '0;
      end else begin
        if (hit[c] && !ret_bad && ret_link != '0 && sem_nx[c] != '0)
          cmdptr_q[c] <= ret_link;
        else if (wr_ptr)
          cmdptr_q[c] <= reg_wdata;
        if (hit[c] && ret_bad)
          chst_q[c] <= ret_err;
        else if (wr_cclr)
          chst_q[c] <= chst_q[c] & ~reg_wdata[ERRW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      gstat_q <= '0;
    end else begin
      if (wr_en) en_q <= reg_wdata[NCH-1:0];
      gstat_q <= (gstat_q & ~(wr_gclr ? reg_wdata[NCH-1:0] : '0)) | irq_set;
    end
  end

  assign irq = |gstat_q;

  dd_arb #(.N(NCH)) u_arb (
    .req (ready),
    .gnt (gnt),
    .any (gnt_any)
  );

  always_comb begin
    gnt_ptr = '0;
    for (int c = 0; c < NCH; c++)
      gnt_ptr = gnt_ptr | ({32{gnt[c]}} & cmdptr_q[c]);
  end

  dd_seq #(.NCH(NCH), .ERRW(ERRW)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .gnt (gnt),
    .gnt_any (gnt_any),
    .gnt_ptr (gnt_ptr),
    .mem_req (mem_req),
    .mem_addr (mem_addr),
    .mem_vld (mem_vld),
    .mem_data (mem_data),
    .eng_start (eng_start),
    .eng_ctrl0 (eng_ctrl0),
    .eng_ctrl1 (eng_ctrl1),
    .eng_src (eng_src),
    .eng_dst (eng_dst),
    .eng_len (eng_len),
    .eng_key (eng_key),
    .eng_done (eng_done),
    .eng_err (eng_err),
    .act_oh (act_oh),
    .grant_fire (grant_fire),
    .ret_fire (ret_fire),
    .ret_dec (ret_dec),
    .ret_irq (ret_irq),
    .ret_err (ret_err),
    .ret_link (ret_link)
  );

  // register read
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(G_STAT)) reg_rdata = 32'(gstat_q);
    if (reg_addr == AW'(G_EN))   reg_rdata = 32'(en_q);
    if (in_ch) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_sel == SELW'(c)) begin
          case (ch_off)
            OFF_PTR:           reg_rdata = cmdptr_q[c];
            OFF_SEM:           reg_rdata = 32'(sem_v[c]);
            OFF_CST, OFF_CCLR: reg_rdata = 32'(chst_q[c]);
            default:           reg_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dd_chk.sv
module dd_chk #(
  parameter int NCH  = 4,
  parameter int ERRW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  act_oh,
  input logic [NCH-1:0]  gnt,
  input logic [NCH-1:0]  ready,
  input logic            grant_fire,
  input logic            mem_req,
  input logic            mem_vld,
  input logic [31:0]     mem_addr,
  input logic            eng_start,
  input logic            ret_fire,
  input logic [ERRW-1:0] ret_err,
  input logic [NCH-1:0]  gstat
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_oh)); // R9
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (((gnt - 1'b1) & ready) == '0) && $countones(gnt) == 1); // R9
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (gnt & ready) != '0); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_vld |=> mem_req && $stable(mem_addr)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R4
  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire && ret_err != '0 |=> (gstat & $past(act_oh)) != '0); // R10
endmodule

bind desc_dispatch dd_chk #(.NCH(NCH), .ERRW(ERRW)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .act_oh (act_oh),
  .gnt (gnt),
  .ready (ready),
  .grant_fire (grant_fire),
  .mem_req (mem_req),
  .mem_vld (mem_vld),
  .mem_addr (mem_addr),
  .eng_start (eng_start),
  .ret_fire (ret_fire),
  .ret_err (ret_err),
  .gstat (gstat_q)
);

// File: tb/sim_desc_dispatch.sv
module sim_desc_dispatch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_vld = 0;
  logic [31:0] mem_addr, mem_data = 0;
  logic        eng_start, eng_done = 0;
  logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_len, eng_key;
  logic [7:0]  eng_err = 0;
  logic        irq;

  always #2 clk = ~clk;

  desc_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_vld(mem_vld), .mem_data(mem_data),
    .eng_start(eng_start), .eng_ctrl0(eng_ctrl0), .eng_ctrl1(eng_ctrl1),
    .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len), .eng_key(eng_key),
    .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
  );

  int total = 0, bad = 0;
  bit ended = 0;

  // memory model: answers two cycles after a request is seen
  logic [31:0] mem [0:255];
  logic [31:0] flog [0:2047];
  int fcnt = 0, mwait = 0;
  always @(negedge clk) begin
    if (mem_vld) begin
      mem_vld = 0; mwait = 0;
    end else if (mem_req) begin
      mwait++;
      if (mwait == 2) begin
        mem_vld = 1;
        mem_data = mem[mem_addr[9:2]];
        if (fcnt < 2048) flog[fcnt] = mem_addr;
        fcnt++;
      end
    end
  end

  // engine stub with fixed latency
  logic [31:0] s_c0 [0:1023], s_c1 [0:1023], s_src [0:1023];
  logic [31:0] s_dst [0:1023], s_len [0:1023], s_key [0:1023];
  int scnt = 0, ecnt = 0;
  logic [7:0] err_next = 0;
  always @(negedge clk) begin
    if (eng_done) begin eng_done = 0; eng_err = 0; end
    if (eng_start) begin
      if (scnt < 1024) begin
        s_c0[scnt] = eng_ctrl0; s_c1[scnt] = eng_ctrl1; s_src[scnt] = eng_src;
        s_dst[scnt] = eng_dst; s_len[scnt] = eng_len; s_key[scnt] = eng_key;
      end
      scnt++;
      ecnt = 3;
    end else if (ecnt != 0) begin
      ecnt--;
      if (ecnt == 0) begin eng_done = 1; eng_err = err_next; end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] chr(int c, int off);
    return 12'(12'h100 + c * 12'h40 + off);
  endfunction

  task automatic put_desc(int ba, logic [31:0] link, logic [31:0] c0, logic [31:0] c1,
                          logic [31:0] src, logic [31:0] dst, logic [31:0] len,
                          logic [31:0] key);
    mem[ba/4] = link; mem[ba/4+1] = c0; mem[ba/4+2] = c1; mem[ba/4+3] = src;
    mem[ba/4+4] = dst; mem[ba/4+5] = len; mem[ba/4+6] = key;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0, f0, k, ch, cnt;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    do_reset();

    // R1 reset state
    rd(12'h010, v); check("R1 gstat", v, 0);
    rd(12'h020, v); check("R1 enable", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(chr(c, 'h00), v); check("R1 cmdptr", v, 0);
      rd(chr(c, 'h10), v); check("R1 sem", v, 0);
      rd(chr(c, 'h20), v); check("R1 chstat", v, 0);
    end
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 eng_start", 32'(eng_start), 0);

    // R2 saturation sweep on a disabled channel; R8 nothing starts
    s0 = scnt;
    for (int n = 1; n <= 260; n++) begin
      wr(chr(3, 'h10), 1);
      rd(chr(3, 'h10), v);
      check("R2 sem count", v, (n > 255) ? 255 : n);
    end
    do_reset();
    wr(chr(1, 'h10), 200); wr(chr(1, 'h10), 200);
    rd(chr(1, 'h10), v); check("R2 sem add saturate", v, 255);
    check("R8 disabled no start", 32'(scnt - s0), 0);

    // R3 R4 R5 R6 R8 R9 enable-mask sweep
    for (int m = 0; m < 16; m++) begin
      do_reset();
      for (int c = 0; c < 4; c++) begin
        put_desc(c * 'h80, 0, 32'hFFFF_FFFF, 32'(c + 7), 32'h1000 + c,
                 32'h2000 + c, 32'(16 * (c + 1)), 32'h3000 + c);
        wr(chr(c, 'h00), 32'(c * 'h80));
        wr(chr(c, 'h10), 1);
      end
      s0 = scnt; f0 = fcnt;
      wr(12'h020, 32'(m));
      repeat (200) @(negedge clk);
      cnt = 0;
      for (int c = 0; c < 4; c++) if (m[c]) cnt++;
      check("R8 start count", 32'(scnt - s0), 32'(cnt));
      k = 0;
      for (int c = 0; c < 4; c++) begin
        if (m[c]) begin
          check("R9 order src", s_src[s0 + k], 32'h1000 + c);
          check("R4 ctrl0 mask", s_c0[s0 + k], 32'h0000_3B60);
          check("R4 ctrl1", s_c1[s0 + k], 32'(c + 7));
          check("R4 dst", s_dst[s0 + k], 32'h2000 + c);
          check("R4 len", s_len[s0 + k], 32'(16 * (c + 1)));
          check("R4 key", s_key[s0 + k], 32'h3000 + c);
          for (int w = 0; w < 7; w++)
            check("R3 fetch addr", flog[f0 + k * 7 + w], 32'(c * 'h80 + 4 * w));
          k++;
        end
        rd(chr(c, 'h10), v);
        check("R5 sem after", v, m[c] ? 0 : 1);
      end
      rd(12'h010, v); check("R6 gstat", v, 32'(m));
      check("R6 irq", 32'(irq), (m != 0) ? 1 : 0);
      wr(12'h018, 32'h5);
      rd(12'h010, v); check("R6 gstat clear", v, 32'(m & 'hA));
    end

    // R7 chaining through a link, then link word with semaphore left
    do_reset();
    put_desc('h80, 32'h0C0, 32'h23, 1, 32'hA, 0, 16, 0);
    put_desc('hC0, 32'h100, 32'h42, 2, 32'hB, 0, 32, 0);
    wr(chr(1, 'h00), 32'h80);
    wr(chr(1, 'h10), 2);
    s0 = scnt;
    wr(12'h020, 32'h2);
    repeat (200) @(negedge clk);
    check("R7 chain runs", 32'(scnt - s0), 2);
    check("R7 first src", s_src[s0], 32'hA);
    check("R7 linked src", s_src[s0 + 1], 32'hB);
    check("R4 chain ctrl0", s_c0[s0 + 1], 32'h40);
    rd(chr(1, 'h00), v); check("R7 ptr at last", v, 32'hC0);
    rd(chr(1, 'h10), v); check("R5 chain sem", v, 0);
    rd(12'h010, v); check("R6 irq flag only", v, 32'h2);

    do_reset();
    put_desc('h100, 0, 32'h2, 0, 32'hC, 0, 16, 0);
    wr(chr(2, 'h00), 32'h100);
    wr(chr(2, 'h10), 3);
    s0 = scnt;
    wr(12'h020, 32'h4);
    repeat (300) @(negedge clk);
    check("R7 rerun count", 32'(scnt - s0), 3);
    rd(chr(2, 'h00), v); check("R7 ptr kept", v, 32'h100);
    rd(12'h010, v); check("R6 no irq flag", v, 0);
    check("R6 irq low", 32'(irq), 0);

    // R10 engine error
    do_reset();
    put_desc('h100, 32'h140, 32'h2, 0, 32'hD, 0, 16, 0);
    wr(chr(2, 'h00), 32'h100);
    wr(chr(2, 'h10), 3);
    err_next = 8'h5A;
    s0 = scnt;
    wr(12'h020, 32'h4);
    repeat (200) @(negedge clk);
    err_next = 0;
    check("R10 one run", 32'(scnt - s0), 1);
    rd(chr(2, 'h20), v); check("R10 chstat", v, 32'h5A);
    rd(chr(2, 'h10), v); check("R10 sem cleared", v, 0);
    rd(chr(2, 'h00), v); check("R10 ptr kept", v, 32'h100);
    rd(12'h010, v); check("R10 gstat", v, 32'h4);
    check("R10 irq", 32'(irq), 1);
    wr(chr(2, 'h28), 32'h0F);
    rd(chr(2, 'h28), v); check("R10 chstat w1c", v, 32'h50);
    wr(12'h018, 32'h4);
    rd(12'h010, v); check("R6 gstat w1c", v, 0);

    // R5 increment colliding with decrement at saturation
    do_reset();
    put_desc(0, 0, 32'h2, 0, 32'hE, 0, 16, 0);
    wr(chr(0, 'h10), 255);
    s0 = scnt;
    wr(12'h020, 32'h1);
    ch = 0;
    while (ch == 0) begin
      @(negedge clk);
      #1 if (eng_done) ch = 1;
    end
    wr(chr(0, 'h10), 1);
    ch = 0;
    while (ch == 0) begin
      @(negedge clk);
      #1 if (scnt - s0 >= 2) ch = 1;
    end
    wr(12'h020, 0);
    rd(chr(0, 'h10), v); check("R5 collide held", v, 255);
    repeat (100) @(negedge clk);
    rd(chr(0, 'h10), v); check("R5 collide sem", v, 254);
    check("R5 collide runs", 32'(scnt - s0), 2);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule